// File: doc/BRIEF.md
# Serial Baud Clock Generator

This block produces the bit-rate timing for a serial port that can run either as an asynchronous UART or as a clock-synchronous shifter. A free-running prescaler offers the system clock undivided or halved, an eighth-rate version and a thirty-second-rate version. One of these is chosen and then divided by a programmable count plus one. A final stage then turns the result into UART timing or into a serial clock for synchronous mode.

In UART modes the block emits a 16x oversampling tick and a bit tick at one sixteenth of that rate. In synchronous master mode it drives a serial clock pin at half the divider rate, with a programmable polarity, and emits a shift tick once per serial clock period. In synchronous slave mode it takes an external clock pin through a synchronizer and turns the active edge into a shift tick. Every timing output is a single-system-clock enable pulse; nothing is a gated clock. The block has no streaming data path, so all pins are plain control and status with no valid/ready handshake.

Top module: `baud_tick_gen`

## Requirements
- R1: With `src_sel`=00 the source period P is 1 system clock when `base_fast`=1 and 2 system clocks when `base_fast`=0.
- R2: With `src_sel`=01 the source period P is 8 clocks; with `src_sel`=10 or the reserved code 11 it is 32 clocks.
- R3: In a UART mode (`mode` = 100, 101 or 110) `os_tick` pulses for one clock every (n+1)*P clocks, where n is the value last written through `rate_val`/`rate_wr`. The first pulse comes exactly (n+1)*P clocks after the restart edge.
- R4: In a UART mode `bit_tick` pulses once per 16 `os_tick` pulses, always together with an `os_tick`. The first comes 16*(n+1)*P clocks after restart.
- R5: In a synchronous mode (`mode` = 001 or 010) with `ext_clk_sel`=0, `sclk_oe` is 1. The internal serial clock starts high, toggles every (n+1)*P clocks, and `shift_tick` pulses as it returns high, first at 2*(n+1)*P clocks after restart.
- R6: In a synchronous mode with `ext_clk_sel`=1, `sclk_oe` is 0 and `shift_tick` pulses once per active edge of `sclk_in`, 3 clocks after the pin changes. In UART modes `ext_clk_sel` is ignored.
- R7: `clk_inv`=1 inverts `sclk_out` (including its idle level), and it makes the falling edge of `sclk_in` the active edge instead of the rising edge.
- R8: Any other `mode` value (000, 011, 111) holds `os_tick`, `bit_tick`, `shift_tick` and `sclk_oe` low, and `sclk_out` idles at 1 XOR `clk_inv`.
- R9: A `rate_wr` pulse, or a change of `mode`, `src_sel`, `base_fast` or `ext_clk_sel`, restarts the prescaler, the (n+1) counter and the final stages. The next period then starts clean from that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_fast | input | 1 | Base clock: 1 undivided, 0 halved |
| src_sel | input | 2 | Source: 00 base, 01 /8, 10 and 11 /32 |
| rate_val | input | RATE_W (8) | Divider value n |
| rate_wr | input | 1 | Loads `rate_val` and restarts timing |
| mode | input | 3 | Serial mode code |
| ext_clk_sel | input | 1 | 1 selects external clock in synchronous mode |
| clk_inv | input | 1 | Serial clock polarity |
| sclk_in | input | 1 | External serial clock pin |
| os_tick | output | 1 | UART 16x oversampling enable |
| bit_tick | output | 1 | UART bit enable |
| shift_tick | output | 1 | Synchronous-mode shift enable |
| sclk_out | output | 1 | Serial clock pin value |
| sclk_oe | output | 1 | Serial clock pin drive enable |

## Verification
The hardest situation to reach is a restart in the middle of a running period. It must abandon the partial prescaler, divider and /16 counts and produce the first tick exactly one full period later. The bench lets UART timing run for an arbitrary stretch that does not line up with a period, rewrites the divider, and measures the first tick relative to that edge. The external-clock path is reached by toggling `sclk_in` from a parallel branch while ticks are counted, once for each polarity, so the 3-cycle synchronizer latency and the edge choice both show up in the first-tick position.

// File: rtl/baud_pkg.sv
package baud_pkg;
  typedef enum logic [1:0] {
    SRC_BASE  = 2'b00,
    SRC_DIV8  = 2'b01,
    SRC_DIV32 = 2'b10,
    SRC_RSVD  = 2'b11
  } src_sel_e;

  function automatic logic mode_is_uart(input logic [2:0] m);
    return (m == 3'b100) || (m == 3'b101) || (m == 3'b110);
  endfunction

  function automatic logic mode_is_sync(input logic [2:0] m);
    return (m == 3'b001) || (m == 3'b010);
  endfunction
endpackage

// File: rtl/baud_prescale.sv
module baud_prescale #(
  parameter int DIV_A = 8,
  parameter int DIV_B = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       base_fast,
  input  logic [1:0] src_sel,
  output logic       src_en
);
  import baud_pkg::*;
  localparam int PRE_W = $clog2(DIV_A * DIV_B);
  localparam int A_W   = $clog2(DIV_A);

  logic [PRE_W-1:0] cnt;
  logic en_base, en_a, en_ab;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else          cnt <= cnt + 1'b1;
  end

  assign en_base = base_fast | cnt[0];
  assign en_a    = &cnt[A_W-1:0];
  assign en_ab   = &cnt;

  always_comb begin
    case (src_sel_e'(src_sel))
      SRC_BASE: src_en = en_base;
      SRC_DIV8: src_en = en_a;
      default:  src_en = en_ab;
    endcase
  end

  // R2: the slowest source only fires on a cycle where the eighth-rate one fires too
  p_slow_nests_r2: assert property (@(posedge clk) disable iff (!rst_n)
    en_ab |-> en_a);
endmodule

// File: rtl/baud_rate_div.sv
module baud_rate_div #(
  parameter int RATE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              src_en,
  input  logic [RATE_W-1:0] n,
  output logic              div_tick
);
  logic [RATE_W-1:0] cnt;

  assign div_tick = src_en && (cnt == n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (clr)      cnt <= '0;
    else if (div_tick) cnt <= '0;
    else if (src_en)   cnt <= cnt + 1'b1;
  end

  p_cnt_bounded_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(clr) |-> cnt <= n);
endmodule

// File: rtl/baud_final.sv
module baud_final #(
  parameter int OS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic div_tick,
  input  logic uart_en,
  input  logic sync_int_en,
  input  logic sync_ext_en,
  input  logic clk_inv,
  input  logic pin_in,
  output logic os_tick,
  output logic bit_tick,
  output logic shift_tick,
  output logic sclk_q,
  output logic oe
);
  localparam int OS_W = $clog2(OS);

  logic [OS_W-1:0] os_cnt;
  logic s1, s2, s3, ext_edge;

  assign ext_edge = clk_inv ? (s3 & ~s2) : (s2 & ~s3);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b0; s2 <= 1'b0; s3 <= 1'b0;
    end else begin
      s1 <= pin_in; s2 <= s1; s3 <= s2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 os_cnt <= '0;
    else if (clr || !uart_en)   os_cnt <= '0;
    else if (div_tick)          os_cnt <= os_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    sclk_q <= 1'b1;
    else if (clr || !sync_int_en)  sclk_q <= 1'b1;
    else if (div_tick)             sclk_q <= ~sclk_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      os_tick <= 1'b0; bit_tick <= 1'b0; shift_tick <= 1'b0; oe <= 1'b0;
    end else begin
      os_tick    <= uart_en & div_tick & ~clr;
      bit_tick   <= uart_en & div_tick & ~clr & (os_cnt == OS_W'(OS - 1));
      shift_tick <= (sync_int_en & div_tick & ~sclk_q & ~clr) | (sync_ext_en & ext_edge);
      oe         <= sync_int_en;
    end
  end

  p_bit_with_os_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |-> os_tick);
  p_uart_sync_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(os_tick && shift_tick));
  p_idle_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !oe |-> sclk_q);
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen #(
  parameter int RATE_W = 8,
  parameter int OS     = 16,
  parameter int DIV_A  = 8,
  parameter int DIV_B  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              base_fast,
  input  logic [1:0]        src_sel,
  input  logic [RATE_W-1:0] rate_val,
  input  logic              rate_wr,
  input  logic [2:0]        mode,
  input  logic              ext_clk_sel,
  input  logic              clk_inv,
  input  logic              sclk_in,
  output logic              os_tick,
  output logic              bit_tick,
  output logic              shift_tick,
  output logic              sclk_out,
  output logic              sclk_oe
);
  import baud_pkg::*;

  logic [RATE_W-1:0] rate_q;
  logic [2:0]        mode_q;
  logic [1:0]        src_q;
  logic              fast_q, ext_q;
  logic              restart, src_en, div_tick, sclk_q;
  logic              uart_en, sync_int_en, sync_ext_en;

  assign uart_en     = mode_is_uart(mode);
  assign sync_int_en = mode_is_sync(mode) & ~ext_clk_sel;
  assign sync_ext_en = mode_is_sync(mode) &  ext_clk_sel;

  assign restart = rate_wr | (mode != mode_q) | (src_sel != src_q)
                 | (base_fast != fast_q) | (ext_clk_sel != ext_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rate_q <= '0; mode_q <= '0; src_q <= '0; fast_q <= 1'b0; ext_q <= 1'b0;
    end else begin
      if (rate_wr) rate_q <= rate_val;
      mode_q <= mode; src_q <= src_sel; fast_q <= base_fast; ext_q <= ext_clk_sel;
    end
  end

  baud_prescale #(.DIV_A(DIV_A), .DIV_B(DIV_B)) u_pre (
    .clk(clk), .rst_n(rst_n), .clr(restart), .base_fast(base_fast),
    .src_sel(src_sel), .src_en(src_en));

  baud_rate_div #(.RATE_W(RATE_W)) u_div (
    .clk(clk), .rst_n(rst_n), .clr(restart), .src_en(src_en),
    .n(rate_q), .div_tick(div_tick));

  baud_final #(.OS(OS)) u_fin (
    .clk(clk), .rst_n(rst_n), .clr(restart), .div_tick(div_tick),
    .uart_en(uart_en), .sync_int_en(sync_int_en), .sync_ext_en(sync_ext_en),
    .clk_inv(clk_inv), .pin_in(sclk_in), .os_tick(os_tick), .bit_tick(bit_tick),
    .shift_tick(shift_tick), .sclk_q(sclk_q), .oe(sclk_oe));

  assign sclk_out = sclk_q ^ clk_inv;

  // R8: a mode code outside both groups for two cycles leaves every output quiet
  p_bad_mode_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!uart_en && !mode_is_sync(mode) && !$past(mode_is_uart(mode)) && !$past(mode_is_sync(mode)))
    |-> (!os_tick && !bit_tick && !shift_tick && !sclk_oe));
  // R6: the pin is never driven while the external clock is in use
  p_ext_no_drive_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(sync_ext_en) |-> !sclk_oe);
endmodule

// File: tb/tb_baud_tick_gen.sv
module tb_baud_tick_gen;
  logic clk = 1'b0, rst_n = 1'b0;
  logic base_fast = 1'b1, rate_wr = 1'b0, ext_clk_sel = 1'b0, clk_inv = 1'b0, sclk_in = 1'b0;
  logic [1:0] src_sel = 2'b00;
  logic [7:0] rate_val = 8'd0;
  logic [2:0] mode = 3'b000;
  logic os_tick, bit_tick, shift_tick, sclk_out, sclk_oe;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  baud_tick_gen dut (.clk(clk), .rst_n(rst_n), .base_fast(base_fast), .src_sel(src_sel),
    .rate_val(rate_val), .rate_wr(rate_wr), .mode(mode), .ext_clk_sel(ext_clk_sel),
    .clk_inv(clk_inv), .sclk_in(sclk_in), .os_tick(os_tick), .bit_tick(bit_tick),
    .shift_tick(shift_tick), .sclk_out(sclk_out), .sclk_oe(sclk_oe));

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic configure(input bit fast, input bit [1:0] src, input int n,
                           input bit [2:0] md, input bit ext, input bit inv);
    @(negedge clk);
    base_fast = fast; src_sel = src; rate_val = 8'(n); mode = md;
    ext_clk_sel = ext; clk_inv = inv; rate_wr = 1'b1;
    @(posedge clk); #1 rate_wr = 1'b0;
  endtask

  // sample index k = state after the k-th edge following the restart edge
  task automatic measure(input int sel, input int w, output int first, output int cnt);
    logic v;
    first = -1; cnt = 0;
    for (int k = 0; k < w; k++) begin
      @(negedge clk);
      v = (sel == 0) ? os_tick : (sel == 1) ? bit_tick : shift_tick;
      if (v) begin
        if (first < 0) first = k;
        cnt++;
      end
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R8 reset os_tick", os_tick, 0);
    chk("R8 reset shift_tick", shift_tick, 0);
    chk("R8 reset sclk_oe", sclk_oe, 0);
    chk("R8 reset sclk_out", sclk_out, 1);
  endtask

  task automatic t_uart(input string req, input bit fast, input bit [1:0] src, input int n,
                        input bit [2:0] md, input int p);
    int f, c, per, w;
    per = (n + 1) * p;
    w = 16 * per + 4;
    configure(fast, src, n, md, 1'b0, 1'b0);
    measure(0, w, f, c);
    chk({req, " R3 os first"}, f, per);
    chk({req, " R3 os count"}, c, (w - 1) / per);
    configure(fast, src, n, md, 1'b0, 1'b0);
    measure(1, w, f, c);
    chk({req, " R4 bit first"}, f, 16 * per);
    chk({req, " R4 bit count"}, c, 1);
  endtask

  task automatic t_uart_ext_ignored;
    int f, c;
    configure(1'b1, 2'b00, 3, 3'b110, 1'b1, 1'b0);
    measure(0, 20, f, c);
    chk("R6 uart ignores ext_clk_sel first", f, 4);
    chk("R6 uart ignores ext_clk_sel oe", sclk_oe, 0);
  endtask

  task automatic t_sync_int(input bit inv);
    int n, per, f, c;
    int lvl0, lvl1, lvl2, oe_v;
    n = 2; per = n + 1;
    configure(1'b1, 2'b00, n, 3'b001, 1'b0, inv);
    lvl0 = -1; lvl1 = -1; lvl2 = -1; oe_v = -1; f = -1; c = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (k == 1) begin lvl0 = sclk_out; oe_v = sclk_oe; end
      if (k == per) lvl1 = sclk_out;
      if (k == 2 * per) lvl2 = sclk_out;
      if (shift_tick) begin if (f < 0) f = k; c++; end
    end
    chk("R5 sync oe", oe_v, 1);
    chk("R7 sclk start level", lvl0, 1 ^ inv);
    chk("R5 sclk after one half", lvl1, 0 ^ inv);
    chk("R5 sclk after full period", lvl2, 1 ^ inv);
    chk("R5 shift first", f, 2 * per);
    chk("R5 shift count", c, 19 / (2 * per));
  endtask

  task automatic t_sync_ext(input bit inv);
    int f, c;
    configure(1'b1, 2'b00, 5, 3'b010, 1'b1, inv);
    fork
      measure(2, 40, f, c);
      begin
        for (int i = 0; i < 5; i++) begin
          @(negedge clk); sclk_in = 1'b1;
          repeat (2) @(negedge clk);
          @(negedge clk); sclk_in = 1'b0;
          repeat (2) @(negedge clk);
        end
      end
    join
    chk("R6 ext oe low", sclk_oe, 0);
    chk("R6 ext tick count", c, 5);
    chk(inv ? "R7 ext falling edge first" : "R6 ext rising edge first", f, inv ? 6 : 3);
  endtask

  task automatic t_bad_mode(input bit [2:0] md);
    int f0, c0, f2, c2;
    configure(1'b1, 2'b00, 0, md, 1'b0, 1'b0);
    fork
      measure(0, 100, f0, c0);
      measure(2, 100, f2, c2);
    join
    chk("R8 bad mode os", c0, 0);
    chk("R8 bad mode shift", c2, 0);
    chk("R8 bad mode oe", sclk_oe, 0);
    chk("R8 bad mode sclk idle", sclk_out, 1);
  endtask

  task automatic t_restart;
    int f, c;
    configure(1'b0, 2'b00, 4, 3'b100, 1'b0, 1'b0);
    repeat (37) @(negedge clk);
    configure(1'b0, 2'b00, 4, 3'b100, 1'b0, 1'b0);
    measure(0, 30, f, c);
    chk("R9 rewrite restarts os", f, 10);
    repeat (23) @(negedge clk);
    @(negedge clk); src_sel = 2'b01;
    @(posedge clk); #1;
    measure(0, 50, f, c);
    chk("R9 source change restarts os", f, 40);
    repeat (11) @(negedge clk);
    configure(1'b0, 2'b01, 1, 3'b100, 1'b0, 1'b0);
    measure(1, 300, f, c);
    chk("R9 restart clears /16 stage", f, 256);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_uart("R1 base undivided", 1'b1, 2'b00, 3, 3'b100, 1);
    t_uart("R1 base halved", 1'b0, 2'b00, 2, 3'b101, 2);
    t_uart("R2 eighth", 1'b1, 2'b01, 1, 3'b110, 8);
    t_uart("R2 thirty-second", 1'b1, 2'b10, 0, 3'b100, 32);
    t_uart("R2 reserved code", 1'b0, 2'b11, 0, 3'b100, 32);
    t_uart_ext_ignored();
    t_sync_int(1'b0);
    t_sync_int(1'b1);
    t_sync_ext(1'b0);
    t_sync_ext(1'b1);
    t_bad_mode(3'b000);
    t_bad_mode(3'b011);
    t_bad_mode(3'b111);
    t_restart();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule